// File: doc/BRIEF.md
# Single-Bit Boolean Engine

This block carries out one-bit operations on an 8-bit bit address space. The lower half of that space covers a bit-addressable window in internal RAM. The upper half covers bit-addressable bytes in the special-function-register area, and the port latches sit in that area. A single carry flag inside the block acts as the Boolean accumulator. The engine can set, clear or complement any bit, move a bit to or from the carry, and fold a bit (or its inverse) into the carry with AND or OR. It can also test a bit for a branch decision. It reports only taken or not taken; target arithmetic and opcode decoding happen elsewhere.

Each command is turned into a byte address and a bit position. The containing byte is read through a byte port with a one-cycle read latency. The changed byte is written back through a separate write port in the following cycle, and only the chosen bit differs. A new command may be issued every cycle. When a write-back and the next command's read hit the same byte in the same cycle, the byte is forwarded internally, so back-to-back commands on one byte behave as if run one after another.

Top module: `bit_engine`

## Requirements
- R1: A bit address below 0x80 selects RAM byte 0x20 + addr[6:3] and bit addr[2:0].
- R2: A bit address of 0x80 or above selects the byte {addr[7:3], 3'b000} and bit addr[2:0].
- R3: Op 4'h1 sets, op 4'h2 clears and op 4'h3 complements the addressed bit. The write-back byte differs from the read byte in that bit only.
- R4: Op 4'h4 copies the addressed bit into the carry. Op 4'h5 writes the carry into the addressed bit.
- R5: Op 4'h6 replaces the carry with carry AND source. Op 4'h7 replaces it with carry OR source. The source is the addressed bit, inverted when cmd_inv is 1. These ops never write memory.
- R6: Ops 4'h8, 4'h9 and 4'hA set, clear and complement the carry without any memory read or write. The carry changes only as a result of an accepted command. Op 4'h0 does nothing.
- R7: Op 4'hB tests the addressed bit. br_valid pulses for one cycle and br_taken is 1 when the bit equals cmd_pol.
- R8: For op 4'hB with cmd_clr at 1, a taken test writes the bit back as 0. A test that is not taken, or has cmd_clr at 0, writes nothing.
- R9: A command that reads the byte written by the command just before it sees the updated byte.
- R10: While rst_n is low, carry, br_valid, br_taken, mem_rd_en and mem_wr_en are all 0, even when cmd_valid is high.
- R11: The read is issued in the same cycle as the command. The write-back appears in the next cycle. The carry and the branch result are updated at the second clock edge after the command is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code (see R3 to R8) |
| cmd_bit | input | 8 | Bit address |
| cmd_inv | input | 1 | Invert source for AND/OR |
| cmd_pol | input | 1 | Bit value that makes a test taken |
| cmd_clr | input | 1 | Clear bit after a taken test |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_rd_addr | output | 8 | Byte read address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | 8 | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| carry | output | 1 | Boolean accumulator |
| br_valid | output | 1 | Test result valid |
| br_taken | output | 1 | Test result |

## Verification
The read for a new command and the write-back of the previous one can fall in the same cycle on the same byte. The bench forces this with directed runs of set, complement, store-carry and clear-on-taken tests on neighbouring bits of one byte, issued every cycle. It also runs a long random stream confined to a few bytes. A behavioural model applies commands strictly one after another to its own byte array. Each clock the write strobe, address and data, the carry and the branch outputs are compared with that model at their stated latencies, and the whole memory is compared at the end.

// File: rtl/bit_engine_pkg.sv
// Package: shared operation codes and helpers for the single-bit engine.
// Assumes a 4-bit operation field supplied by an external decoder.
package bit_engine_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_SETB = 4'h1,
        OP_CLRB = 4'h2,
        OP_CPLB = 4'h3,
        OP_LDC  = 4'h4,
        OP_STC  = 4'h5,
        OP_ANDC = 4'h6,
        OP_ORC  = 4'h7,
        OP_SETC = 4'h8,
        OP_CLRC = 4'h9,
        OP_CPLC = 4'hA,
        OP_TEST = 4'hB
    } bop_t;

    // True when the operation needs the containing byte from memory.
    function automatic logic op_reads(input bop_t op);
        case (op)
            OP_SETB, OP_CLRB, OP_CPLB, OP_LDC, OP_STC,
            OP_ANDC, OP_ORC, OP_TEST: op_reads = 1'b1;
            default:                  op_reads = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bit_addr_map.sv
// Module: bit_addr_map
// Turns a bit address into a byte address and a bit position.
// The lower half of the space maps into a RAM window starting at RAM_BASE.
// The upper half maps onto byte addresses aligned to the bits-per-byte.
// Assumes ADDR_W-1 > POS_W and that the RAM window fits below the upper half.
module bit_addr_map #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic [ADDR_W-1:0]         bit_addr,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0] bit_pos
);
    localparam int POS_W     = $clog2(DATA_W);
    localparam int IDX_W     = ADDR_W - 1 - POS_W;
    localparam int RAM_BYTES = 2 ** IDX_W;
    localparam logic [ADDR_W-1:0] RAM_END = RAM_BASE + ADDR_W'(RAM_BYTES);

    logic                 upper;
    logic [IDX_W-1:0]     ram_idx;

    // Split the address into region, index and position.
    always_comb begin
        upper   = bit_addr[ADDR_W-1];
        ram_idx = bit_addr[ADDR_W-2:POS_W];
        bit_pos = bit_addr[POS_W-1:0];
        if (upper)
            byte_addr = {bit_addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        else
            byte_addr = RAM_BASE + {{(ADDR_W-IDX_W){1'b0}}, ram_idx};
    end

    // Mapped addresses stay inside their region.
    always_comb begin
        if (!$isunknown(bit_addr)) begin
            if (!bit_addr[ADDR_W-1]) begin
                a_r1_ram_window: assert (byte_addr >= RAM_BASE && byte_addr < RAM_END)
                    else $error("R1 mapped RAM byte outside window");
            end else begin
                a_r2_sfr_aligned: assert (byte_addr[POS_W-1:0] == '0 && byte_addr[ADDR_W-1])
                    else $error("R2 upper-region byte not aligned");
            end
        end
    end

endmodule

// File: rtl/bit_alu.sv
// Module: bit_alu
// Purely combinational bit operation unit.
// It reads one bit of the fetched byte and produces the new byte, a write request,
// the new carry with its enable, and the test outcome.
// Assumes old_byte is already the up-to-date content of the addressed byte.
module bit_alu
    import bit_engine_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bop_t                       op,
    input  logic [$clog2(DATA_W)-1:0]  pos,
    input  logic                       inv,
    input  logic                       pol,
    input  logic                       clr,
    input  logic [DATA_W-1:0]          old_byte,
    input  logic                       carry_in,
    output logic [DATA_W-1:0]          new_byte,
    output logic                       wr_req,
    output logic                       carry_out,
    output logic                       carry_we,
    output logic                       is_test,
    output logic                       taken
);
    logic bit_val;
    logic src;

    // Pick the addressed bit and the optionally inverted source.
    always_comb begin
        bit_val = old_byte[pos];
        src     = bit_val ^ inv;
    end

    // Apply the selected operation.
    always_comb begin
        new_byte  = old_byte;
        wr_req    = 1'b0;
        carry_out = carry_in;
        carry_we  = 1'b0;
        is_test   = 1'b0;
        taken     = 1'b0;
        case (op)
            OP_SETB: begin new_byte[pos] = 1'b1;     wr_req = 1'b1; end
            OP_CLRB: begin new_byte[pos] = 1'b0;     wr_req = 1'b1; end
            OP_CPLB: begin new_byte[pos] = ~bit_val; wr_req = 1'b1; end
            OP_STC:  begin new_byte[pos] = carry_in; wr_req = 1'b1; end
            OP_LDC:  begin carry_out = bit_val;          carry_we = 1'b1; end
            OP_ANDC: begin carry_out = carry_in & src;   carry_we = 1'b1; end
            OP_ORC:  begin carry_out = carry_in | src;   carry_we = 1'b1; end
            OP_SETC: begin carry_out = 1'b1;             carry_we = 1'b1; end
            OP_CLRC: begin carry_out = 1'b0;             carry_we = 1'b1; end
            OP_CPLC: begin carry_out = ~carry_in;        carry_we = 1'b1; end
            OP_TEST: begin
                is_test = 1'b1;
                taken   = (bit_val == pol);
                if (clr && taken) begin
                    new_byte[pos] = 1'b0;
                    wr_req        = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // A write-back never disturbs more than the selected bit.
    always_comb begin
        if (wr_req && !$isunknown(old_byte) && !$isunknown(new_byte)) begin
            a_r3_single_bit: assert ($countones(new_byte ^ old_byte) <= 1)
                else $error("R3 write-back changed more than one bit");
        end
    end

endmodule

// File: rtl/bit_engine.sv
// Module: bit_engine
// Top of the single-bit Boolean engine. It is a two-stage flow:
//   stage 0: map the bit address and issue the byte read;
//   stage 1: operate on the returned byte, write it back, and update carry and branch result.
// Assumes memory returns read data one cycle after mem_rd_en.
// A write and a read of the same byte in one cycle return the old data; the engine
// forwards its own write in that case.
module bit_engine
    import bit_engine_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                OP_W     = 4,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_bit,
    input  logic              cmd_inv,
    input  logic              cmd_pol,
    input  logic              cmd_clr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              carry,
    output logic              br_valid,
    output logic              br_taken
);
    localparam int POS_W = $clog2(DATA_W);

    bop_t              in_op;
    logic [POS_W-1:0]  in_pos;
    logic [ADDR_W-1:0] in_byte;

    logic              s1_valid;
    bop_t              s1_op;
    logic [POS_W-1:0]  s1_pos;
    logic [ADDR_W-1:0] s1_addr;
    logic              s1_inv, s1_pol, s1_clr;

    logic              fwd_hit_q;
    logic [DATA_W-1:0] fwd_data_q;
    logic [DATA_W-1:0] cur_byte;

    logic [DATA_W-1:0] alu_new;
    logic              alu_wr, alu_cout, alu_cwe, alu_test, alu_taken;

    logic              carry_q, br_valid_q, br_taken_q;

    // Interpret the raw opcode field as an operation.
    always_comb in_op = bop_t'(cmd_op);

    bit_addr_map #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RAM_BASE (RAM_BASE)
    ) u_map (
        .bit_addr  (cmd_bit),
        .byte_addr (in_byte),
        .bit_pos   (in_pos)
    );

    // Issue the byte read in the command cycle.
    always_comb begin
        mem_rd_en   = rst_n && cmd_valid && op_reads(in_op);
        mem_rd_addr = in_byte;
    end

    // Capture the command for the operate stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_NOP;
            s1_pos   <= '0;
            s1_addr  <= '0;
            s1_inv   <= 1'b0;
            s1_pol   <= 1'b0;
            s1_clr   <= 1'b0;
        end else begin
            s1_valid <= cmd_valid;
            s1_op    <= cmd_valid ? in_op : OP_NOP;
            s1_pos   <= in_pos;
            s1_addr  <= in_byte;
            s1_inv   <= cmd_inv;
            s1_pol   <= cmd_pol;
            s1_clr   <= cmd_clr;
        end
    end

    // Remember a write that collides with the read issued in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_hit_q  <= 1'b0;
            fwd_data_q <= '0;
        end else begin
            fwd_hit_q  <= mem_wr_en && mem_rd_en && (mem_wr_addr == mem_rd_addr);
            fwd_data_q <= mem_wr_data;
        end
    end

    // Select the current content of the addressed byte.
    always_comb cur_byte = fwd_hit_q ? fwd_data_q : mem_rd_data;

    bit_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op        (s1_op),
        .pos       (s1_pos),
        .inv       (s1_inv),
        .pol       (s1_pol),
        .clr       (s1_clr),
        .old_byte  (cur_byte),
        .carry_in  (carry_q),
        .new_byte  (alu_new),
        .wr_req    (alu_wr),
        .carry_out (alu_cout),
        .carry_we  (alu_cwe),
        .is_test   (alu_test),
        .taken     (alu_taken)
    );

    // Drive the write-back port from the operate stage.
    always_comb begin
        mem_wr_en   = rst_n && s1_valid && alu_wr;
        mem_wr_addr = s1_addr;
        mem_wr_data = alu_new;
    end

    // Update the Boolean accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (s1_valid && alu_cwe)
            carry_q <= alu_cout;
    end

    // Register the branch decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_valid_q <= 1'b0;
            br_taken_q <= 1'b0;
        end else begin
            br_valid_q <= s1_valid && alu_test;
            br_taken_q <= s1_valid && alu_test && alu_taken;
        end
    end

    // Present the registered state.
    always_comb begin
        carry    = carry_q;
        br_valid = br_valid_q;
        br_taken = br_taken_q;
    end

    // Carry-only ops never touch memory.
    a_r6_carry_ops_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_op == OP_SETC || s1_op == OP_CLRC || s1_op == OP_CPLC)) |-> !mem_wr_en)
        else $error("R6 carry op wrote memory");

    // The carry moves only after an accepted command.
    a_r6_carry_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q != $past(carry_q)) |-> $past(s1_valid))
        else $error("R6 carry changed without a command");

    // A test that is not taken leaves memory alone.
    a_r8_no_write_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_op == OP_TEST && !alu_taken) |-> !mem_wr_en)
        else $error("R8 write on a test that was not taken");

    // AND/OR into carry never write memory.
    a_r5_logic_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_op == OP_ANDC || s1_op == OP_ORC)) |-> !mem_wr_en)
        else $error("R5 logic op wrote memory");

    // A branch result follows an operate-stage command.
    a_r11_br_after_stage: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_q |-> $past(s1_valid))
        else $error("R11 branch result without a command");

    // A forwarded byte always comes from a real write.
    a_r9_fwd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit_q |-> $past(mem_wr_en))
        else $error("R9 forward without a write");

endmodule

// File: tb/bit_engine_bench.sv
`timescale 1ns/1ps
module bit_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [3:0] cmd_op;
    logic [7:0] cmd_bit;
    logic       cmd_inv, cmd_pol, cmd_clr;
    logic       mem_rd_en, mem_wr_en;
    logic [7:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [7:0] mem_rd_data;
    logic       carry, br_valid, br_taken;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    bit_engine u_bit_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_inv(cmd_inv), .cmd_pol(cmd_pol), .cmd_clr(cmd_clr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .carry(carry), .br_valid(br_valid), .br_taken(br_taken)
    );

    // Memory seen by the design: one-cycle read, old data on a same-cycle collision.
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    // Reference state.
    int    ref_mem [256];
    bit    ref_c;
    bit    ew_en;   int ew_addr; int ew_data; string ew_tag;
    bit    ec1, ec2, ebv1, ebv2, ebt1, ebt2;
    string et1, et2;

    task automatic check(string tag, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int map_byte(int a);
        return (a < 128) ? (32 + a / 8) : (a & 248);
    endfunction

    // One clock: compare with the model, then present the next command.
    task automatic step(bit v, int op, int a, bit inv, bit pol, bit clr, string tag);
        int  b, p, oldv, nb;
        bit  bit_v, src, wen, bv, bt;
        @(negedge clk);
        check(ew_tag, int'(mem_wr_en), int'(ew_en), "wr_en");
        if (ew_en) begin
            check(ew_tag, int'(mem_wr_addr), ew_addr, "wr_addr");
            check(ew_tag, int'(mem_wr_data), ew_data, "wr_data");
        end
        check(et2, int'(carry), int'(ec2), "carry");
        check(et2, int'(br_valid), int'(ebv2), "br_valid");
        if (ebv2) check(et2, int'(br_taken), int'(ebt2), "br_taken");
        ec2 = ec1; ebv2 = ebv1; ebt2 = ebt1; et2 = et1;
        wen = 0; bv = 0; bt = 0; b = 0; nb = 0;
        if (v) begin
            b = map_byte(a); p = a % 8;
            oldv = ref_mem[b]; nb = oldv;
            bit_v = oldv[p]; src = bit_v ^ inv;
            case (op)
                1:  begin nb[p] = 1'b1;   wen = 1; end
                2:  begin nb[p] = 1'b0;   wen = 1; end
                3:  begin nb[p] = ~bit_v; wen = 1; end
                4:  ref_c = bit_v;
                5:  begin nb[p] = ref_c;  wen = 1; end
                6:  ref_c = ref_c & src;
                7:  ref_c = ref_c | src;
                8:  ref_c = 1;
                9:  ref_c = 0;
                10: ref_c = ~ref_c;
                11: begin
                        bv = 1; bt = (bit_v == pol);
                        if (bt && clr) begin nb[p] = 1'b0; wen = 1; end
                    end
                default: ;
            endcase
            if (wen) ref_mem[b] = nb;
        end
        ew_en = wen; ew_addr = b; ew_data = nb; ew_tag = tag;
        ec1 = ref_c; ebv1 = bv; ebt1 = bt; et1 = tag;
        cmd_valid = v; cmd_op = op[3:0]; cmd_bit = a[7:0];
        cmd_inv = inv; cmd_pol = pol; cmd_clr = clr;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'((i * 37 + 5) & 255);
            ref_mem[i] = (i * 37 + 5) & 255;
        end
        rst_n = 0; cmd_valid = 1; cmd_op = 4'h1; cmd_bit = 8'h10;
        cmd_inv = 0; cmd_pol = 0; cmd_clr = 0;
        ref_c = 0; ew_en = 0; ew_addr = 0; ew_data = 0; ew_tag = "R11";
        ec1 = 0; ec2 = 0; ebv1 = 0; ebv2 = 0; ebt1 = 0; ebt2 = 0; et1 = "R10"; et2 = "R10";
        repeat (3) @(negedge clk);
        // R10: everything quiet while reset is held, even with a command offered.
        check("R10", int'(carry), 0, "carry");
        check("R10", int'(br_valid), 0, "br_valid");
        check("R10", int'(br_taken), 0, "br_taken");
        check("R10", int'(mem_rd_en), 0, "rd_en");
        check("R10", int'(mem_wr_en), 0, "wr_en");
        rst_n = 1; cmd_valid = 0;

        // R1: RAM window corners and middle; R11 latency checked every step.
        step(1, 1, 8'h00, 0, 0, 0, "R1");
        step(1, 1, 8'h7F, 0, 0, 0, "R1");
        step(1, 2, 8'h35, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R11");
        // R2: upper region.
        step(1, 1, 8'h80, 0, 0, 0, "R2");
        step(1, 2, 8'hD7, 0, 0, 0, "R2");
        step(1, 3, 8'hFF, 0, 0, 0, "R2");
        // R3: complement twice with a gap.
        step(1, 3, 8'h42, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        step(1, 3, 8'h42, 0, 0, 0, "R3");
        // R4: load carry then store it elsewhere.
        step(1, 1, 8'h11, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R4");
        step(1, 4, 8'h11, 0, 0, 0, "R4");
        step(1, 5, 8'h90, 0, 0, 0, "R4");
        step(1, 9, 0, 0, 0, 0, "R4");
        step(1, 5, 8'h91, 0, 0, 0, "R4");
        // R5: AND/OR with and without inversion.
        step(1, 8, 0, 0, 0, 0, "R5");
        step(1, 6, 8'h20, 1, 0, 0, "R5");
        step(1, 7, 8'h21, 0, 0, 0, "R5");
        step(1, 6, 8'h00, 0, 0, 0, "R5");
        step(1, 7, 8'h00, 1, 0, 0, "R5");
        // R6: carry-only ops and NOP.
        step(1, 10, 0, 0, 0, 0, "R6");
        step(1, 10, 0, 0, 0, 0, "R6");
        step(1, 0, 8'h33, 0, 0, 0, "R6");
        step(1, 9, 0, 0, 0, 0, "R6");
        // R7/R8: tests of both polarities, clear on taken only.
        step(1, 11, 8'h00, 0, 1, 0, "R7");
        step(1, 11, 8'h00, 0, 0, 0, "R7");
        step(1, 11, 8'h7F, 0, 1, 1, "R8");
        step(1, 11, 8'h7F, 0, 1, 1, "R8");
        step(1, 11, 8'h35, 0, 1, 1, "R8");
        // R9: back-to-back commands on one byte.
        step(1, 1, 8'h08, 0, 0, 0, "R9");
        step(1, 3, 8'h09, 0, 0, 0, "R9");
        step(1, 4, 8'h08, 0, 0, 0, "R9");
        step(1, 5, 8'h0A, 0, 0, 0, "R9");
        step(1, 11, 8'h0A, 0, 1, 1, "R9");
        step(1, 11, 8'h0A, 0, 1, 0, "R9");
        step(1, 3, 8'hC0, 0, 0, 0, "R9");
        step(1, 3, 8'hC0, 0, 0, 0, "R9");
        step(1, 4, 8'hC0, 0, 0, 0, "R9");
        // Random stream focused on few bytes.
        for (int k = 0; k < 600; k++) begin
            int a;
            a = ($urandom % 2) ? int'($urandom % 24) : int'($urandom % 256);
            step(($urandom % 5) != 0, int'($urandom % 12), a,
                 $urandom % 2, $urandom % 2, $urandom % 2, "R9");
        end
        step(0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R11");
        // R3: final memory image matches the model.
        for (int i = 0; i < 256; i++) check("R3", int'(mem[i]), ref_mem[i], "mem image");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R11 watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule